// File: doc/BRIEF.md
# MII Receive Nibble Deframer

This block sits directly behind the receive pins of a 10/100 media-independent interface and turns the 4-bit nibble stream into a byte stream. All of its inputs are sampled on the rising edge of the receive clock, and every output is a register in that clock domain. Inside a frame, it skips a preamble of any length made of 0x5 nibbles, including a missing or partial one. It locks byte alignment on the first 0xD nibble and then pairs the nibbles that follow into bytes, low nibble first. Each byte carries a start flag and an error flag. The close of the frame is reported by an end strobe, which carries a misalignment flag when the frame stops on half a byte.

Outside a frame, the valid line is low while the error line is high. In that condition the nibble bus carries a control word. The block decodes these words into a low-power-idle level and into single-cycle pulses for beacon, commit and false carrier.

The deframer uses five states:
- ST_IDLE: between frames.
- ST_PREAMBLE: 0x5 nibbles seen, no delimiter yet.
- ST_LOW: waiting for the low nibble of a byte.
- ST_HIGH: waiting for the high nibble of a byte.
- ST_DISCARD: frame rejected, waiting for valid to drop.

The transitions are as follows:
- From ST_IDLE or ST_PREAMBLE, a valid 0x5 nibble moves to ST_PREAMBLE.
- From ST_IDLE or ST_PREAMBLE, a valid 0xD nibble moves to ST_LOW.
- From ST_IDLE or ST_PREAMBLE, any other valid nibble, or a valid nibble with error high, moves to ST_DISCARD and raises an abort pulse.
- From ST_PREAMBLE, valid low returns to ST_IDLE.
- ST_LOW moves to ST_HIGH on each valid nibble.
- ST_HIGH moves back to ST_LOW on each valid nibble and emits a byte.
- ST_LOW with valid low ends the frame aligned and returns to ST_IDLE.
- ST_HIGH with valid low ends the frame misaligned and returns to ST_IDLE.
- ST_DISCARD returns to ST_IDLE when valid drops.

Top module: `mii_rx_deframer`

## Requirements
- R1: While reset is asserted, every output of the block is 0.
- R2: After zero or more valid 0x5 nibbles, a valid 0xD nibble starts the frame. Each following pair of valid nibbles forms one byte, with out_byte[3:0] taken from the first nibble of the pair and out_byte[7:4] from the second.
- R3: out_sof is 1 on the first byte of a frame and 0 on every other byte.
- R4: out_err is 1 on a byte if the error input was high during either of its two nibbles, and 0 otherwise.
- R5: When valid falls after an even number of post-delimiter nibbles, frm_end pulses for one cycle with frm_misalign 0. The pulse comes in the cycle after the last byte, never together with out_vld.
- R6: When valid falls after an odd number of post-delimiter nibbles, the trailing nibble produces no byte, and frm_end pulses with frm_misalign 1.
- R7: If valid falls before any 0xD nibble was seen, the block emits no byte, no frm_end and no frm_abort.
- R8: Before the delimiter, a valid nibble other than 0x5 or 0xD, or any valid nibble with error high, raises frm_abort for one cycle. The rest of that frame then yields no byte and no frm_end.
- R9: lpi_stat is 1 for exactly as many cycles as the input holds valid 0, error 1, nibble 0001. It clears on the first cycle with any other input condition.
- R10: With valid 0 and error 1, each run of nibble 0010 gives one beacon_pls, each run of 0011 gives one commit_pls, and each run of 1110 gives one fcar_pls. A run is counted from its first cycle, and a direct change from one code to another starts a new run.
- R11: With both valid and error low, or with valid 0, error 1 and a nibble not listed in R9 or R10, no status output is raised.
- R12: A byte appears on out_byte/out_vld on the second rising edge after its high nibble is presented at the inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock; all inputs sampled on its rising edge |
| rst_n | input | 1 | Active-low reset |
| rxd | input | 4 | Receive nibble bus |
| rx_valid | input | 1 | Receive data-valid |
| rx_error | input | 1 | Receive error / control-word qualifier |
| out_byte | output | 8 | Assembled byte |
| out_vld | output | 1 | out_byte holds a new byte this cycle |
| out_sof | output | 1 | Byte is the first of its frame |
| out_err | output | 1 | Byte was received with an error |
| frm_end | output | 1 | Frame closed (one cycle) |
| frm_misalign | output | 1 | Closed frame ended on a half byte |
| frm_abort | output | 1 | Preamble contained an illegal nibble (one cycle) |
| lpi_stat | output | 1 | Low-power-idle control word present |
| beacon_pls | output | 1 | Start of a beacon control word |
| commit_pls | output | 1 | Start of a commit control word |
| fcar_pls | output | 1 | Start of a false-carrier control word |

## Verification
The assertions assume the inputs are stable around each rising clock edge and free of unknown values. They also assume that a frame, once started, keeps valid high until its last nibble, so that valid is never toggled mid-byte by anything other than a frame end. The stimulus changes every input only on the falling edge. It always returns valid to 0 for several cycles between frames and control-word runs, so each scenario starts from ST_IDLE. Control words are only ever driven with valid low, which matches the assertion that bytes and status pulses never coincide.

// File: rtl/mii_rx_pkg.sv
package mii_rx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PREAMBLE,
        ST_LOW,
        ST_HIGH,
        ST_DISCARD
    } rx_state_t;

    localparam int unsigned NUM_PULSE = 3;
    localparam int unsigned PULSE_BEACON = 0;
    localparam int unsigned PULSE_COMMIT = 1;
    localparam int unsigned PULSE_FCAR   = 2;

endpackage

// File: rtl/mii_rx_sampler.sv
module mii_rx_sampler #(
    parameter int unsigned NIB_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NIB_W-1:0] pin_nib,
    input  logic             pin_dv,
    input  logic             pin_er,
    output logic [NIB_W-1:0] s_nib,
    output logic             s_dv,
    output logic             s_er
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_nib <= '0;
            s_dv  <= 1'b0;
            s_er  <= 1'b0;
        end else begin
            s_nib <= pin_nib;
            s_dv  <= pin_dv;
            s_er  <= pin_er;
        end
    end

endmodule

// File: rtl/mii_rx_ctrl_decode.sv
module mii_rx_ctrl_decode
    import mii_rx_pkg::*;
#(
    parameter int unsigned              NIB_W       = 4,
    parameter logic [NIB_W-1:0]         CODE_LPI    = 4'b0001,
    parameter logic [NUM_PULSE*NIB_W-1:0] PULSE_CODES = {4'b1110, 4'b0011, 4'b0010}
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NIB_W-1:0]     s_nib,
    input  logic                 s_dv,
    input  logic                 s_er,
    output logic                 lpi_o,
    output logic [NUM_PULSE-1:0] pulse_o
);

    logic             ctrl_now;
    logic             prev_ctrl;
    logic [NIB_W-1:0] prev_nib;

    assign ctrl_now = !s_dv && s_er;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_ctrl <= 1'b0;
            prev_nib  <= '0;
            lpi_o     <= 1'b0;
        end else begin
            prev_ctrl <= ctrl_now;
            prev_nib  <= s_nib;
            lpi_o     <= ctrl_now && (s_nib == CODE_LPI);
        end
    end

    for (genvar g = 0; g < NUM_PULSE; g++) begin : g_pulse
        localparam logic [NIB_W-1:0] CODE = PULSE_CODES[g*NIB_W +: NIB_W];
        logic hit_now;
        logic hit_prev;
        assign hit_now  = ctrl_now && (s_nib == CODE);
        assign hit_prev = prev_ctrl && (prev_nib == CODE);
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                pulse_o[g] <= 1'b0;
            end else begin
                pulse_o[g] <= hit_now && !hit_prev;
            end
        end
    end

endmodule

// File: rtl/mii_rx_frame_fsm.sv
module mii_rx_frame_fsm
    import mii_rx_pkg::*;
#(
    parameter int unsigned      NIB_W   = 4,
    parameter logic [NIB_W-1:0] PRE_NIB = 4'h5,
    parameter logic [NIB_W-1:0] SFD_NIB = 4'hD,
    localparam int unsigned     BYTE_W  = 2 * NIB_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NIB_W-1:0]  s_nib,
    input  logic              s_dv,
    input  logic              s_er,
    output logic [BYTE_W-1:0] out_byte,
    output logic              out_vld,
    output logic              out_sof,
    output logic              out_err,
    output logic              frm_end,
    output logic              frm_misalign,
    output logic              frm_abort
);

    rx_state_t        state_q;
    rx_state_t        state_d;
    logic [NIB_W-1:0] lo_nib_q;
    logic             lo_err_q;
    logic             first_q;
    logic             pre_bad;
    logic             pre_sfd;

    assign pre_bad = s_er || ((s_nib != PRE_NIB) && (s_nib != SFD_NIB));
    assign pre_sfd = !s_er && (s_nib == SFD_NIB);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE, ST_PREAMBLE: begin
                if (!s_dv) begin
                    state_d = ST_IDLE;
                end else if (pre_bad) begin
                    state_d = ST_DISCARD;
                end else if (pre_sfd) begin
                    state_d = ST_LOW;
                end else begin
                    state_d = ST_PREAMBLE;
                end
            end
            ST_LOW: begin
                state_d = s_dv ? ST_HIGH : ST_IDLE;
            end
            ST_HIGH: begin
                state_d = s_dv ? ST_LOW : ST_IDLE;
            end
            ST_DISCARD: begin
                state_d = s_dv ? ST_DISCARD : ST_IDLE;
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_byte     <= '0;
            out_vld      <= 1'b0;
            out_sof      <= 1'b0;
            out_err      <= 1'b0;
            frm_end      <= 1'b0;
            frm_misalign <= 1'b0;
            frm_abort    <= 1'b0;
            lo_nib_q     <= '0;
            lo_err_q     <= 1'b0;
            first_q      <= 1'b0;
        end else begin
            out_vld      <= 1'b0;
            out_sof      <= 1'b0;
            out_err      <= 1'b0;
            frm_end      <= 1'b0;
            frm_misalign <= 1'b0;
            frm_abort    <= 1'b0;
            unique case (state_q)
                ST_IDLE, ST_PREAMBLE: begin
                    if (s_dv) begin
                        if (pre_bad) begin
                            frm_abort <= 1'b1;
                        end else if (pre_sfd) begin
                            first_q <= 1'b1;
                        end
                    end
                end
                ST_LOW: begin
                    if (s_dv) begin
                        lo_nib_q <= s_nib;
                        lo_err_q <= s_er;
                    end else begin
                        frm_end <= 1'b1;
                    end
                end
                ST_HIGH: begin
                    if (s_dv) begin
                        out_byte <= {s_nib, lo_nib_q};
                        out_vld  <= 1'b1;
                        out_err  <= lo_err_q || s_er;
                        out_sof  <= first_q;
                        first_q  <= 1'b0;
                    end else begin
                        frm_end      <= 1'b1;
                        frm_misalign <= 1'b1;
                    end
                end
                ST_DISCARD: begin
                end
                default: begin
                end
            endcase
        end
    end

endmodule

// File: rtl/mii_rx_deframer.sv
module mii_rx_deframer
    import mii_rx_pkg::*;
#(
    parameter int unsigned      NIB_W       = 4,
    parameter logic [NIB_W-1:0] PRE_NIB     = 4'h5,
    parameter logic [NIB_W-1:0] SFD_NIB     = 4'hD,
    parameter logic [NIB_W-1:0] CODE_LPI    = 4'b0001,
    parameter logic [NIB_W-1:0] CODE_BEACON = 4'b0010,
    parameter logic [NIB_W-1:0] CODE_COMMIT = 4'b0011,
    parameter logic [NIB_W-1:0] CODE_FCAR   = 4'b1110,
    localparam int unsigned     BYTE_W      = 2 * NIB_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NIB_W-1:0]  rxd,
    input  logic              rx_valid,
    input  logic              rx_error,
    output logic [BYTE_W-1:0] out_byte,
    output logic              out_vld,
    output logic              out_sof,
    output logic              out_err,
    output logic              frm_end,
    output logic              frm_misalign,
    output logic              frm_abort,
    output logic              lpi_stat,
    output logic              beacon_pls,
    output logic              commit_pls,
    output logic              fcar_pls
);

    logic [NIB_W-1:0]     s_nib;
    logic                 s_dv;
    logic                 s_er;
    logic [NUM_PULSE-1:0] pulses;

    mii_rx_sampler #(.NIB_W(NIB_W)) sampler_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin_nib (rxd),
        .pin_dv  (rx_valid),
        .pin_er  (rx_error),
        .s_nib   (s_nib),
        .s_dv    (s_dv),
        .s_er    (s_er)
    );

    mii_rx_frame_fsm #(
        .NIB_W   (NIB_W),
        .PRE_NIB (PRE_NIB),
        .SFD_NIB (SFD_NIB)
    ) fsm_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .s_nib        (s_nib),
        .s_dv         (s_dv),
        .s_er         (s_er),
        .out_byte     (out_byte),
        .out_vld      (out_vld),
        .out_sof      (out_sof),
        .out_err      (out_err),
        .frm_end      (frm_end),
        .frm_misalign (frm_misalign),
        .frm_abort    (frm_abort)
    );

    mii_rx_ctrl_decode #(
        .NIB_W       (NIB_W),
        .CODE_LPI    (CODE_LPI),
        .PULSE_CODES ({CODE_FCAR, CODE_COMMIT, CODE_BEACON})
    ) ctrl_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .s_nib   (s_nib),
        .s_dv    (s_dv),
        .s_er    (s_er),
        .lpi_o   (lpi_stat),
        .pulse_o (pulses)
    );

    assign beacon_pls = pulses[PULSE_BEACON];
    assign commit_pls = pulses[PULSE_COMMIT];
    assign fcar_pls   = pulses[PULSE_FCAR];

endmodule

// File: rtl/mii_rx_deframer_chk.sv
module mii_rx_deframer_chk (
    input logic clk,
    input logic rst_n,
    input logic out_vld,
    input logic out_sof,
    input logic out_err,
    input logic frm_end,
    input logic frm_misalign,
    input logic frm_abort,
    input logic lpi_stat,
    input logic beacon_pls,
    input logic commit_pls,
    input logic fcar_pls
);

    AST_SOF_ONLY_ON_BYTE: assert property (@(posedge clk) disable iff (!rst_n) out_sof |-> out_vld); // R3
    AST_ERR_ONLY_ON_BYTE: assert property (@(posedge clk) disable iff (!rst_n) out_err |-> out_vld); // R4
    AST_END_NOT_WITH_BYTE: assert property (@(posedge clk) disable iff (!rst_n) frm_end |-> !out_vld); // R5
    AST_END_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) frm_end |=> !frm_end); // R5
    AST_MISALIGN_WITH_END: assert property (@(posedge clk) disable iff (!rst_n) frm_misalign |-> frm_end); // R6
    AST_ABORT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) frm_abort |=> !frm_abort); // R8
    AST_ABORT_ALONE: assert property (@(posedge clk) disable iff (!rst_n) frm_abort |-> !(out_vld || frm_end)); // R8
    AST_STATUS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n) $onehot0({lpi_stat, beacon_pls, commit_pls, fcar_pls})); // R10
    AST_BEACON_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) beacon_pls |=> !beacon_pls); // R10
    AST_COMMIT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) commit_pls |=> !commit_pls); // R10
    AST_FCAR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) fcar_pls |=> !fcar_pls); // R10
    AST_STATUS_NOT_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n) out_vld |-> !(lpi_stat || beacon_pls || commit_pls || fcar_pls)); // R11

endmodule

bind mii_rx_deframer mii_rx_deframer_chk chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .out_vld      (out_vld),
    .out_sof      (out_sof),
    .out_err      (out_err),
    .frm_end      (frm_end),
    .frm_misalign (frm_misalign),
    .frm_abort    (frm_abort),
    .lpi_stat     (lpi_stat),
    .beacon_pls   (beacon_pls),
    .commit_pls   (commit_pls),
    .fcar_pls     (fcar_pls)
);

// File: tb/mii_rx_deframer_tb_top.sv
module mii_rx_deframer_tb_top;

    localparam int CLK_PERIOD = 40;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] rxd = 4'h0;
    logic       rx_valid = 1'b0;
    logic       rx_error = 1'b0;
    logic [7:0] out_byte;
    logic       out_vld, out_sof, out_err, frm_end, frm_misalign, frm_abort;
    logic       lpi_stat, beacon_pls, commit_pls, fcar_pls;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    // monitor log (monotonic counters only)
    logic [7:0] got_byte [256];
    bit         got_sof  [256];
    bit         got_err  [256];
    int nbytes = 0, nend = 0, nmis = 0, nabort = 0;
    int nlpi = 0, nbeacon = 0, ncommit = 0, nfcar = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mii_rx_deframer dut_i (
        .clk(clk), .rst_n(rst_n), .rxd(rxd), .rx_valid(rx_valid), .rx_error(rx_error),
        .out_byte(out_byte), .out_vld(out_vld), .out_sof(out_sof), .out_err(out_err),
        .frm_end(frm_end), .frm_misalign(frm_misalign), .frm_abort(frm_abort),
        .lpi_stat(lpi_stat), .beacon_pls(beacon_pls), .commit_pls(commit_pls), .fcar_pls(fcar_pls)
    );

    always @(negedge clk) begin
        if (rst_n) begin
            if (out_vld) begin
                got_byte[nbytes[7:0]] <= out_byte;
                got_sof[nbytes[7:0]]  <= out_sof;
                got_err[nbytes[7:0]]  <= out_err;
                nbytes <= nbytes + 1;
            end
            if (frm_end)      nend    <= nend + 1;
            if (frm_misalign) nmis    <= nmis + 1;
            if (frm_abort)    nabort  <= nabort + 1;
            if (lpi_stat)     nlpi    <= nlpi + 1;
            if (beacon_pls)   nbeacon <= nbeacon + 1;
            if (commit_pls)   ncommit <= ncommit + 1;
            if (fcar_pls)     nfcar   <= nfcar + 1;
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic drv(input logic dv, input logic er, input logic [3:0] n);
        @(negedge clk);
        rx_valid = dv;
        rx_error = er;
        rxd      = n;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) drv(1'b0, 1'b0, 4'h0);
    endtask

    task automatic send_byte(input logic [7:0] b, input logic er_lo, input logic er_hi);
        drv(1'b1, er_lo, b[3:0]);
        drv(1'b1, er_hi, b[7:4]);
    endtask

    task automatic start_frame(input int npre);
        for (int i = 0; i < npre; i++) drv(1'b1, 1'b0, 4'h5);
        drv(1'b1, 1'b0, 4'hD);
    endtask

    task automatic check_bytes(input string req, input int base, input logic [7:0] exp [4], input int n);
        for (int i = 0; i < n; i++) begin
            chk(req, $sformatf("byte %0d value", i), int'(got_byte[(base + i) % 256]), int'(exp[i]));
            chk("R3", $sformatf("byte %0d sof", i), int'(got_sof[(base + i) % 256]), (i == 0) ? 1 : 0);
        end
    endtask

    task automatic t_reset;
        // R1: all outputs low during reset
        chk("R1", "outputs in reset",
            int'({out_byte, out_vld, out_sof, out_err, frm_end, frm_misalign, frm_abort,
                  lpi_stat, beacon_pls, commit_pls, fcar_pls}), 0);
    endtask

    task automatic t_frame(input string req, input int npre);
        logic [7:0] exp [4];
        int b0 = nbytes, e0 = nend, m0 = nmis, a0 = nabort;
        exp[0] = 8'hA7; exp[1] = 8'h3C; exp[2] = 8'hF0; exp[3] = 8'h81;
        start_frame(npre);
        for (int i = 0; i < 4; i++) send_byte(exp[i], 1'b0, 1'b0);
        idle(4);
        chk(req, "byte count", nbytes - b0, 4);
        check_bytes(req, b0, exp, 4);
        chk("R4", "no error flag", int'(got_err[b0 % 256]) + int'(got_err[(b0 + 3) % 256]), 0);
        chk("R5", "end strobes", nend - e0, 1);
        chk("R5", "misalign strobes", nmis - m0, 0);
        chk(req, "abort strobes", nabort - a0, 0);
    endtask

    task automatic t_err_bytes;
        int b0 = nbytes;
        start_frame(2);
        send_byte(8'h11, 1'b0, 1'b0);
        send_byte(8'h22, 1'b0, 1'b1);
        send_byte(8'h33, 1'b1, 1'b0);
        send_byte(8'h44, 1'b0, 1'b0);
        idle(4);
        chk("R4", "byte count", nbytes - b0, 4);
        chk("R4", "err byte0", int'(got_err[b0 % 256]), 0);
        chk("R4", "err byte1 (high nibble)", int'(got_err[(b0 + 1) % 256]), 1);
        chk("R4", "err byte2 (low nibble)", int'(got_err[(b0 + 2) % 256]), 1);
        chk("R4", "err byte3", int'(got_err[(b0 + 3) % 256]), 0);
    endtask

    task automatic t_odd_tail;
        int b0 = nbytes, e0 = nend, m0 = nmis;
        start_frame(5);
        send_byte(8'h5A, 1'b0, 1'b0);
        send_byte(8'hC3, 1'b0, 1'b0);
        drv(1'b1, 1'b0, 4'h9);
        idle(4);
        chk("R6", "byte count with tail", nbytes - b0, 2);
        chk("R6", "last byte", int'(got_byte[(b0 + 1) % 256]), 8'hC3);
        chk("R6", "end strobes", nend - e0, 1);
        chk("R6", "misalign strobes", nmis - m0, 1);
    endtask

    task automatic t_no_sfd;
        int b0 = nbytes, e0 = nend, a0 = nabort;
        for (int i = 0; i < 6; i++) drv(1'b1, 1'b0, 4'h5);
        idle(4);
        chk("R7", "bytes", nbytes - b0, 0);
        chk("R7", "ends", nend - e0, 0);
        chk("R7", "aborts", nabort - a0, 0);
    endtask

    task automatic t_bad_pre(input logic er, input logic [3:0] bad);
        int b0 = nbytes, e0 = nend, a0 = nabort;
        drv(1'b1, 1'b0, 4'h5);
        drv(1'b1, 1'b0, 4'h5);
        drv(1'b1, er, bad);
        drv(1'b1, 1'b0, 4'hD);
        send_byte(8'h77, 1'b0, 1'b0);
        send_byte(8'h66, 1'b0, 1'b0);
        idle(4);
        chk("R8", "aborts", nabort - a0, 1);
        chk("R8", "bytes after abort", nbytes - b0, 0);
        chk("R8", "ends after abort", nend - e0, 0);
    endtask

    task automatic t_lpi;
        int l0 = nlpi, bc0 = nbeacon;
        for (int i = 0; i < 12; i++) drv(1'b0, 1'b1, 4'b0001);
        idle(4);
        chk("R9", "lpi cycles", nlpi - l0, 12);
        chk("R9", "lpi cleared", int'(lpi_stat), 0);
        l0 = nlpi;
        for (int i = 0; i < 4; i++) drv(1'b0, 1'b1, 4'b0001);
        drv(1'b0, 1'b1, 4'b0010);
        idle(4);
        chk("R9", "lpi cycles before beacon", nlpi - l0, 4);
        chk("R10", "beacon after lpi", nbeacon - bc0, 1);
    endtask

    task automatic t_pulses;
        int bc0 = nbeacon, c0 = ncommit, f0 = nfcar;
        for (int i = 0; i < 5; i++) drv(1'b0, 1'b1, 4'b0010);
        for (int i = 0; i < 3; i++) drv(1'b0, 1'b1, 4'b0011);
        idle(2);
        for (int i = 0; i < 2; i++) drv(1'b0, 1'b1, 4'b1110);
        drv(1'b0, 1'b1, 4'b0010);
        idle(4);
        chk("R10", "beacon pulses", nbeacon - bc0, 2);
        chk("R10", "commit pulses", ncommit - c0, 1);
        chk("R10", "false carrier pulses", nfcar - f0, 1);
    endtask

    task automatic t_ignore;
        int s0 = nlpi + nbeacon + ncommit + nfcar;
        idle(5);
        drv(1'b0, 1'b1, 4'b0000);
        drv(1'b0, 1'b1, 4'b0100);
        drv(1'b0, 1'b1, 4'b1111);
        drv(1'b0, 1'b0, 4'b0001);
        drv(1'b0, 1'b0, 4'b0010);
        idle(4);
        chk("R11", "status events", nlpi + nbeacon + ncommit + nfcar - s0, 0);
    endtask

    task automatic t_latency;
        drv(1'b1, 1'b0, 4'hD);
        drv(1'b1, 1'b0, 4'h6);
        drv(1'b1, 1'b0, 4'hB);
        drv(1'b0, 1'b0, 4'h0);
        chk("R12", "vld one edge after high nibble", int'(out_vld), 0);
        drv(1'b0, 1'b0, 4'h0);
        chk("R12", "vld two edges after high nibble", int'(out_vld), 1);
        chk("R12", "byte value", int'(out_byte), 8'hB6);
        idle(4);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        idle(3);
        t_frame("R2", 14);
        t_frame("R2", 0);
        t_frame("R2", 3);
        t_err_bytes();
        t_odd_tail();
        t_no_sfd();
        t_bad_pre(1'b0, 4'hA);
        t_bad_pre(1'b1, 4'h5);
        t_lpi();
        t_pulses();
        t_ignore();
        t_latency();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            tests++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule